// File: doc/BRIEF.md
# Transport Packet Control-Word Selector

This block sits between a transport stream header parser and a payload cipher core. For every transport packet, and for every PES header found inside a packet, it decides whether the payload needs descrambling. When it does, it supplies the 64-bit control word to use. It also hands back the scrambling bits that the outgoing header must carry, which are cleared whenever descrambling is applied.

A host programs the block through a register write port. There are six PID filter entries. Each entry has an enable, a PES-enable flag and an index into a bank of six odd/even key pairs, so several entries may share one pair. There is also one default key with its own valid bit. A transport code of 01 selects the default key for any PID. Codes 10 and 11 select the even or odd key of the pair that the lowest-numbered matching entry points to. For every entry that matches, the block also records the incoming scrambling bits in status outputs the host can read.

Host key writes and default-valid writes go to a staging copy. That copy becomes live at the next packet start strobe, so no packet or PES header ever sees a half-written key.

Top module: `cw_selector`

## Requirements
- R1: A packet start with transport code 00 gives, one cycle later, `out_vld_o`=1, `out_pes_o`=0, `desc_en_o`=0 and `sc_o`=00. When no event is strobed, `out_vld_o` is 0 in the next cycle.
- R2: A packet start with transport code 01 and the default-valid bit set (register 0x08, bit 0) gives `desc_en_o`=1, `sc_o`=00 and the default key, whatever the PID and whatever any filter entry holds.
- R3: With the default-valid bit clear, a packet start with code 01 gives `desc_en_o`=0 and `sc_o`=01 (unchanged).
- R4: A packet start with code 10 (even) or 11 (odd) whose PID matches an enabled filter entry gives `desc_en_o`=1, `sc_o`=00, and that entry pair's even or odd key. Filter entry e is written at address e (0..5): PID in bits 12:0, enable in bit 13, PES-enable in bit 14, pair index in bits 18:16.
- R5: Codes 10 and 11 pass clear with `sc_o` unchanged when the PID matches no enabled entry, or when the matched entry's pair index is 6 or more.
- R6: When several enabled entries hold the same PID, the lowest-numbered one supplies the pair index.
- R7: A PES header strobe (without a packet start) uses the entry matched by the current packet. With PES code 10 or 11 and that entry's PES-enable set, it gives `out_pes_o`=1, `desc_en_o`=1, `sc_o`=00 and the even or odd key. PES codes 00 and 01 always pass clear with `sc_o` unchanged, so the default key is never chosen.
- R8: A PES header whose packet matched no entry, or matched an entry without PES-enable, passes clear with `sc_o` unchanged.
- R9: `key_o` is all zeros whenever `desc_en_o` is 0, including after reset.
- R10: On a packet start, the transport code is recorded in `ts_sc_log_o[2e+1:2e]` for every enabled entry e whose PID matches. On a PES header, the PES code is recorded in `pes_sc_log_o[2e+1:2e]` for every entry that matched the packet and has PES-enable set. The pair index has no effect on this recording. Both logs reset to zero.
- R11: Key slot s (pair p even s=2p, odd s=2p+1, default s=12) is written as a low half at 0x20+2s and a high half at 0x20+2s+1. Key writes and default-valid writes take effect at the next packet start, and that packet already uses them. PES headers before that start still use the earlier keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Host register write strobe |
| cfg_addr_i | input | 6 | Host register address |
| cfg_wdata_i | input | 32 | Host register write data |
| pkt_start_i | input | 1 | Transport packet header strobe |
| pid_i | input | 13 | PID of the packet, valid with pkt_start_i |
| ts_sc_i | input | 2 | Transport scrambling code, valid with pkt_start_i |
| pes_hdr_i | input | 1 | PES header strobe |
| pes_sc_i | input | 2 | PES scrambling code, valid with pes_hdr_i |
| out_vld_o | output | 1 | Decision valid, one cycle after a strobe |
| out_pes_o | output | 1 | Decision belongs to a PES header |
| desc_en_o | output | 1 | Payload must be descrambled |
| key_o | output | 64 | Selected control word |
| sc_o | output | 2 | Scrambling code to write into the header |
| ts_sc_log_o | output | 12 | Last transport code per filter entry |
| pes_sc_log_o | output | 12 | Last PES code per filter entry |

## Verification
The assertions assume the parser never raises `pkt_start_i` and `pes_hdr_i` in the same cycle, and that every PES header follows at least one packet start. They also assume the strobed codes are stable for the single strobe cycle. The bench drives each strobe alone for exactly one cycle and begins with a packet before any PES header. Its random phase mixes host writes between events, including rewrites of entries and keys between a packet and its PES headers, so the staging rule is exercised.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int NUM_ENT  = 6;
  localparam int NUM_PAIR = 6;
  localparam int PID_W    = 13;
  localparam int KEY_W    = 64;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam int ENT_W    = $clog2(NUM_ENT);
  localparam int PAIR_W   = $clog2(NUM_PAIR);
  localparam int NUM_SLOT = 2 * NUM_PAIR + 1;
  localparam int SLOT_W   = $clog2(NUM_SLOT);
  localparam int DCW_SLOT = 2 * NUM_PAIR;

  // entry word fields
  localparam int F_EN   = PID_W;
  localparam int F_PES  = PID_W + 1;
  localparam int F_PAIR = 16;

  localparam logic [ADDR_W-1:0] A_DCWV = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(32);

  typedef struct packed {
    logic [PAIR_W-1:0] pair;
    logic              is_pes;
    logic              en;
    logic [PID_W-1:0]  pid;
  } ent_t;

  typedef enum logic [1:0] {
    SC_CLEAR = 2'b00,
    SC_DFLT  = 2'b01,
    SC_EVEN  = 2'b10,
    SC_ODD   = 2'b11
  } sc_e;
endpackage

// File: rtl/cws_filter.sv
module cws_filter
  import cws_pkg::*;
#(
  parameter int NE = NUM_ENT
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [PID_W-1:0]            pid_i,
  output logic [NE-1:0][PAIR_W-1:0]   pair_o,
  output logic [NE-1:0]               pes_o,
  output logic [NE-1:0]               match_o,
  output logic                        hit_o,
  output logic [ENT_W-1:0]            idx_o
);
  ent_t [NE-1:0] ents_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:F_PAIR+PAIR_W], wdata_i[F_PAIR-1:F_PES+1]};

  for (genvar e = 0; e < NE; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ents_q[e] <= '0;
      end else if (we_i && addr_i == ADDR_W'(e)) begin
        ents_q[e].pid    <= wdata_i[PID_W-1:0];
        ents_q[e].en     <= wdata_i[F_EN];
        ents_q[e].is_pes <= wdata_i[F_PES];
        ents_q[e].pair   <= wdata_i[F_PAIR +: PAIR_W];
      end
    end
    assign match_o[e] = ents_q[e].en && (ents_q[e].pid == pid_i);
    assign pair_o[e]  = ents_q[e].pair;
    assign pes_o[e]   = ents_q[e].is_pes;
  end

  // lowest matching entry wins
  always_comb begin
    idx_o = '0;
    for (int e = NE - 1; e >= 0; e--) begin
      if (match_o[e]) idx_o = ENT_W'(e);
    end
  end
  assign hit_o = |match_o;
endmodule

// File: rtl/cws_keys.sv
module cws_keys
  import cws_pkg::*;
#(
  parameter int NS = NUM_SLOT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  input  logic              rd_stg_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [KEY_W-1:0]  key_o,
  output logic              dcwv_o
);
  localparam int HALVES = KEY_W / DATA_W;
  localparam int HW     = $clog2(HALVES);

  logic [NS-1:0][KEY_W-1:0] stg_q, act_q;
  logic                     stg_dv_q, act_dv_q;
  logic [ADDR_W-1:0]        off;
  logic                     key_we;
  logic [SLOT_W-1:0]        slot;
  logic [HW-1:0]            half;

  assign off    = addr_i - A_KEY;
  assign key_we = we_i && (addr_i >= A_KEY) && (off < ADDR_W'(NS * HALVES));
  assign slot   = SLOT_W'(off >> HW);
  assign half   = off[HW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q    <= '0;
      act_q    <= '0;
      stg_dv_q <= 1'b0;
      act_dv_q <= 1'b0;
    end else begin
      if (key_we) stg_q[slot][int'(half)*DATA_W +: DATA_W] <= wdata_i;
      if (we_i && addr_i == A_DCWV) stg_dv_q <= wdata_i[0];
      if (commit_i) begin
        act_q    <= stg_q;
        act_dv_q <= stg_dv_q;
      end
    end
  end

  // the committing packet reads the staged copy directly
  assign key_o  = rd_stg_i ? stg_q[rd_slot_i] : act_q[rd_slot_i];
  assign dcwv_o = rd_stg_i ? stg_dv_q : act_dv_q;
endmodule

// File: rtl/cws_decide.sv
module cws_decide
  import cws_pkg::*;
#(
  parameter int NP = NUM_PAIR
) (
  input  logic              pes_i,
  input  logic [1:0]        sc_i,
  input  logic              hit_i,
  input  logic [PAIR_W-1:0] pair_i,
  input  logic              ent_pes_i,
  input  logic              dcwv_i,
  output logic              en_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [1:0]        sc_o
);
  logic pair_ok;
  assign pair_ok = hit_i && (pair_i < PAIR_W'(NP));

  always_comb begin
    en_o   = 1'b0;
    slot_o = SLOT_W'({pair_i, sc_i[0]});
    if (!pes_i) begin
      unique case (sc_e'(sc_i))
        SC_CLEAR: en_o = 1'b0;
        SC_DFLT: begin
          en_o   = dcwv_i;
          slot_o = SLOT_W'(DCW_SLOT);
        end
        default:  en_o = pair_ok;
      endcase
    end else begin
      // PES level never selects the default key
      en_o = sc_i[1] && pair_ok && ent_pes_i;
    end
    sc_o = en_o ? SC_CLEAR : sc_i;
  end
endmodule

// File: rtl/cw_selector.sv
module cw_selector
  import cws_pkg::*;
#(
  parameter int NE = NUM_ENT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              pkt_start_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [1:0]        ts_sc_i,
  input  logic              pes_hdr_i,
  input  logic [1:0]        pes_sc_i,
  output logic              out_vld_o,
  output logic              out_pes_o,
  output logic              desc_en_o,
  output logic [KEY_W-1:0]  key_o,
  output logic [1:0]        sc_o,
  output logic [2*NE-1:0]   ts_sc_log_o,
  output logic [2*NE-1:0]   pes_sc_log_o
);
  logic [NE-1:0][PAIR_W-1:0] f_pair;
  logic [NE-1:0]             f_pes, f_match;
  logic                      f_hit;
  logic [ENT_W-1:0]          f_idx;

  logic [NE-1:0]             ctx_match_q;
  logic                      ctx_hit_q;
  logic [ENT_W-1:0]          ctx_idx_q;

  logic                      pes_evt;
  logic                      sel_hit;
  logic [ENT_W-1:0]          sel_idx;
  logic [1:0]                sel_sc;
  logic                      d_en;
  logic [SLOT_W-1:0]         d_slot;
  logic [1:0]                d_sc;
  logic [KEY_W-1:0]          k_key;
  logic                      k_dcwv;

  assign pes_evt = pes_hdr_i && !pkt_start_i;

  cws_filter #(.NE(NE)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .pid_i   (pid_i),
    .pair_o  (f_pair),
    .pes_o   (f_pes),
    .match_o (f_match),
    .hit_o   (f_hit),
    .idx_o   (f_idx)
  );

  // packet context for following PES headers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_match_q <= '0;
      ctx_hit_q   <= 1'b0;
      ctx_idx_q   <= '0;
    end else if (pkt_start_i) begin
      ctx_match_q <= f_match;
      ctx_hit_q   <= f_hit;
      ctx_idx_q   <= f_idx;
    end
  end

  assign sel_hit = pkt_start_i ? f_hit : ctx_hit_q;
  assign sel_idx = pkt_start_i ? f_idx : ctx_idx_q;
  assign sel_sc  = pkt_start_i ? ts_sc_i : pes_sc_i;

  cws_keys u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .commit_i  (pkt_start_i),
    .rd_stg_i  (pkt_start_i),
    .rd_slot_i (d_slot),
    .key_o     (k_key),
    .dcwv_o    (k_dcwv)
  );

  cws_decide u_decide (
    .pes_i     (pes_evt),
    .sc_i      (sel_sc),
    .hit_i     (sel_hit),
    .pair_i    (f_pair[sel_idx]),
    .ent_pes_i (f_pes[sel_idx]),
    .dcwv_i    (k_dcwv),
    .en_o      (d_en),
    .slot_o    (d_slot),
    .sc_o      (d_sc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      out_pes_o <= 1'b0;
      desc_en_o <= 1'b0;
      key_o     <= '0;
      sc_o      <= '0;
    end else begin
      out_vld_o <= pkt_start_i || pes_evt;
      out_pes_o <= pes_evt;
      desc_en_o <= (pkt_start_i || pes_evt) && d_en;
      key_o     <= ((pkt_start_i || pes_evt) && d_en) ? k_key : '0;
      sc_o      <= (pkt_start_i || pes_evt) ? d_sc : 2'b00;
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_log
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ts_sc_log_o[2*e +: 2]  <= 2'b00;
        pes_sc_log_o[2*e +: 2] <= 2'b00;
      end else begin
        if (pkt_start_i && f_match[e]) ts_sc_log_o[2*e +: 2] <= ts_sc_i;
        if (pes_evt && ctx_match_q[e] && f_pes[e]) pes_sc_log_o[2*e +: 2] <= pes_sc_i;
      end
    end
  end
endmodule

// File: rtl/cws_checker.sv
module cws_checker
  import cws_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_start_i,
  input logic [1:0]       ts_sc_i,
  input logic             pes_hdr_i,
  input logic [1:0]       pes_sc_i,
  input logic             out_vld_o,
  input logic             out_pes_o,
  input logic             desc_en_o,
  input logic [KEY_W-1:0] key_o,
  input logic [1:0]       sc_o
);
  p_pkt_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_i |=> out_vld_o && !out_pes_o);

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_start_i && !pes_hdr_i |=> !out_vld_o);

  p_ts_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_i && ts_sc_i == 2'b00 |=> !desc_en_o && sc_o == 2'b00);

  p_rewrite_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_en_o |-> sc_o == 2'b00);

  p_pes_no_default_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pes_hdr_i && !pkt_start_i && !pes_sc_i[1] |=>
      out_pes_o && !desc_en_o && sc_o == $past(pes_sc_i));

  p_key_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !desc_en_o |-> key_o == '0);
endmodule

bind cw_selector cws_checker u_chk (.*);

// File: tb/sim_cw_selector.sv
`timescale 1ns/1ps
module sim_cw_selector;
  import cws_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        pkt_start_i = 1'b0;
  logic [12:0] pid_i = '0;
  logic [1:0]  ts_sc_i = '0;
  logic        pes_hdr_i = 1'b0;
  logic [1:0]  pes_sc_i = '0;
  logic        out_vld_o, out_pes_o, desc_en_o;
  logic [63:0] key_o;
  logic [1:0]  sc_o;
  logic [11:0] ts_sc_log_o, pes_sc_log_o;

  always #2 clk = ~clk;

  cw_selector u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .pkt_start_i(pkt_start_i), .pid_i(pid_i),
    .ts_sc_i(ts_sc_i), .pes_hdr_i(pes_hdr_i), .pes_sc_i(pes_sc_i),
    .out_vld_o(out_vld_o), .out_pes_o(out_pes_o), .desc_en_o(desc_en_o),
    .key_o(key_o), .sc_o(sc_o), .ts_sc_log_o(ts_sc_log_o), .pes_sc_log_o(pes_sc_log_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  int          m_pid [6];
  bit          m_en  [6];
  bit          m_pes [6];
  int          m_pair[6];
  logic [63:0] m_stg [13];
  logic [63:0] m_act [13];
  bit          m_dv_stg = 1'b0;
  bit          m_dv_act = 1'b0;
  bit          m_ctx_mm[6];
  bit          m_ctx_hit = 1'b0;
  int          m_ctx_idx = 0;
  logic [11:0] m_ts_log = '0;
  logic [11:0] m_pes_log = '0;

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input int pid, input bit en, input bit pes, input int pair);
    return (32'(pair & 7) << 16) | (32'(pes) << 14) | (32'(en) << 13) | 32'(pid & 'h1fff);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    int ai;
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    ai = int'(a);
    if (ai < 6) begin
      m_pid[ai] = int'(d[12:0]); m_en[ai] = d[13]; m_pes[ai] = d[14]; m_pair[ai] = int'(d[18:16]);
    end
    if (ai == 8) m_dv_stg = d[0];
    if (ai >= 32 && ai < 32 + 26) begin
      if (a[0]) m_stg[(ai - 32) / 2][63:32] = d;
      else      m_stg[(ai - 32) / 2][31:0]  = d;
    end
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic outputs_check(input string t, input bit pes, input bit en,
                               input logic [63:0] k, input logic [1:0] sco);
    check(t, "out_vld", 64'(out_vld_o), 64'(1));
    check(t, "out_pes", 64'(out_pes_o), 64'(pes));
    check(t, "desc_en", 64'(desc_en_o), 64'(en));
    check(t, "sc_out", 64'(sc_o), 64'(sco));
    check(en ? t : "R9", "key", key_o, en ? k : 64'd0);
    check("R10", "ts_log", 64'(ts_sc_log_o), 64'(m_ts_log));
    check("R10", "pes_log", 64'(pes_sc_log_o), 64'(m_pes_log));
  endtask

  task automatic send_pkt(input int pid, input logic [1:0] sc, input string tag);
    bit hit = 1'b0;
    int idx = 0;
    int nm = 0;
    bit en = 1'b0;
    logic [63:0] k = '0;
    logic [1:0] sco;
    string t;
    @(negedge clk);
    for (int i = 5; i >= 0; i--) begin
      m_ctx_mm[i] = m_en[i] && (m_pid[i] == pid);
      if (m_ctx_mm[i]) begin hit = 1'b1; idx = i; nm++; end
    end
    for (int s = 0; s < 13; s++) m_act[s] = m_stg[s];
    m_dv_act = m_dv_stg;
    m_ctx_hit = hit; m_ctx_idx = idx;
    if (sc == 2'b01) begin
      en = m_dv_act; k = m_act[12];
    end else if (sc[1] && hit && m_pair[idx] < 6) begin
      en = 1'b1; k = m_act[m_pair[idx] * 2 + int'(sc[0])];
    end
    sco = en ? 2'b00 : sc;
    for (int i = 0; i < 6; i++) if (m_ctx_mm[i]) m_ts_log[2*i +: 2] = sc;
    if (tag != "") t = tag;
    else if (sc == 2'b00) t = "R1";
    else if (sc == 2'b01) t = m_dv_act ? "R2" : "R3";
    else if (!en) t = "R5";
    else t = (nm > 1) ? "R6" : "R4";
    pkt_start_i = 1'b1; pid_i = 13'(pid); ts_sc_i = sc;
    @(negedge clk);
    pkt_start_i = 1'b0;
    outputs_check(t, 1'b0, en, k, sco);
  endtask

  task automatic send_pes(input logic [1:0] sc, input string tag);
    bit en;
    logic [63:0] k = '0;
    logic [1:0] sco;
    string t;
    @(negedge clk);
    en = m_ctx_hit && sc[1] && m_pes[m_ctx_idx] && (m_pair[m_ctx_idx] < 6);
    if (en) k = m_act[m_pair[m_ctx_idx] * 2 + int'(sc[0])];
    sco = en ? 2'b00 : sc;
    for (int i = 0; i < 6; i++) if (m_ctx_mm[i] && m_pes[i]) m_pes_log[2*i +: 2] = sc;
    if (tag != "") t = tag;
    else t = (en || !sc[1]) ? "R7" : "R8";
    pes_hdr_i = 1'b1; pes_sc_i = sc;
    @(negedge clk);
    pes_hdr_i = 1'b0;
    outputs_check(t, 1'b1, en, k, sco);
  endtask

  function automatic int pick_pid();
    case ($urandom % 5)
      0: return 'h100;
      1: return 'h200;
      2: return 'h300;
      3: return 'h500;
      default: return int'($urandom % 8192);
    endcase
  endfunction

  initial begin
    int seed;
    for (int i = 0; i < 6; i++) begin m_pid[i] = 0; m_en[i] = 0; m_pes[i] = 0; m_pair[i] = 0; m_ctx_mm[i] = 0; end
    for (int s = 0; s < 13; s++) begin m_stg[s] = '0; m_act[s] = '0; end
    seed = int'($urandom(32'd7041));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "reset out_vld", 64'(out_vld_o), 64'd0);
    check("R9", "reset desc_en", 64'(desc_en_o), 64'd0);
    check("R9", "reset key", key_o, 64'd0);
    check("R10", "reset ts_log", 64'(ts_sc_log_o), 64'd0);
    check("R10", "reset pes_log", 64'(pes_sc_log_o), 64'd0);

    for (int s = 0; s < 13; s++) begin
      wr(6'(32 + 2 * s), $urandom);
      wr(6'(33 + 2 * s), $urandom);
    end
    wr(6'd8, 32'd1);
    wr(6'd0, ent('h100, 1, 1, 2));
    wr(6'd1, ent('h200, 1, 0, 5));
    wr(6'd2, ent('h100, 1, 0, 0));
    wr(6'd3, ent('h300, 1, 1, 7));
    wr(6'd4, ent('h400, 0, 1, 1));
    wr(6'd5, ent('h500, 1, 1, 4));

    send_pkt('h100, 2'b10, "R6");
    send_pkt('h100, 2'b11, "R4");
    send_pkt('h999, 2'b01, "R2");
    send_pkt('h200, 2'b01, "R2");
    send_pkt('h999, 2'b10, "R5");
    send_pkt('h300, 2'b11, "R5");
    send_pkt('h400, 2'b10, "R5");
    send_pkt('h200, 2'b00, "R1");
    wr(6'd8, 32'd0);
    send_pkt('h100, 2'b01, "R3");
    wr(6'd8, 32'd1);
    send_pkt('h100, 2'b10, "");
    send_pes(2'b10, "R7");
    send_pes(2'b11, "R7");
    send_pes(2'b01, "R7");
    send_pes(2'b00, "R7");
    send_pkt('h200, 2'b11, "");
    send_pes(2'b10, "R8");
    send_pkt('h999, 2'b00, "");
    send_pes(2'b11, "R8");
    send_pkt('h500, 2'b10, "");
    wr(6'(32 + 2 * 8), 32'hDEAD0001);
    send_pes(2'b10, "R11");
    send_pkt('h500, 2'b10, "R11");

    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 20);
      if (op < 3)       wr(6'($urandom % 6), ($urandom & 32'h0007_6000) | 32'(pick_pid()));
      else if (op < 5)  wr(6'(32 + $urandom % 26), $urandom);
      else if (op == 5) wr(6'd8, 32'($urandom % 2));
      else if (op < 14) send_pkt(pick_pid(), 2'($urandom % 4), "");
      else              send_pes(2'($urandom % 4), "");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule